// File: doc/BRIEF.md
# Dual-Mode Segment Address Translator

This block converts a segment value (or selector) and a 16-bit offset into a 24-bit physical address. A single mode input, sampled with each request, chooses between two addressing schemes. In real mode the segment value is multiplied by sixteen and added to the offset. The result is a 20-bit address that wraps inside a 1 MB window and is zero-extended to 24 bits. In protected mode the low bits of the selector pick one entry of a small descriptor cache. Each entry holds a 24-bit base, a 16-bit limit and a valid flag. The offset is added to the base, and the offset is also compared against the limit.

The descriptor cache is loaded through a dedicated write port. A translation is requested with a one-cycle strobe. The result appears on the cycle after the request, registered together with a response strobe and a fault flag. In protected mode, a fault replaces the address when the offset is above the limit or the chosen entry is not valid. A large region can be built from several adjacent selectors. Each selector except the last uses the full 64 KB limit, and the bases are set one full segment apart.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid, rsp_fault and rsp_addr are all 0, and every descriptor entry is invalid, so any protected-mode translation faults until an entry is written.
- R2: With mode = 0 (real), the result is ({req_sel, 4'b0000} + req_ofs) mod 2^20, zero-extended to 24 bits, and rsp_fault is 0.
- R3: rsp_valid is 1 exactly in the cycle after a cycle with req_valid = 1, and is 0 otherwise. Back-to-back requests give back-to-back responses. rsp_fault is 0 whenever rsp_valid is 0.
- R4: With mode = 1 (protected), a valid entry and req_ofs <= limit, the result is (base + req_ofs) mod 2^24 and rsp_fault is 0. An offset equal to the limit is legal.
- R5: With mode = 1 and req_ofs strictly greater than the entry's limit, rsp_fault is 1 and rsp_addr is 0.
- R6: With mode = 1 and the selected entry's valid flag clear, rsp_fault is 1 and rsp_addr is 0.
- R7: In protected mode the entry index is req_sel[2:0]. Selector bits 15:3 have no effect on the result.
- R8: With dw_en = 1, entry dw_idx takes dw_base, dw_limit and dw_valid at the clock edge. dw_valid = 0 invalidates the entry. A translation in the same cycle as a write uses the entry's previous contents.
- R9: The mode is taken per request, so consecutive requests may alternate between real and protected addressing.
- R10: Adjacent selectors whose bases differ by 0x10000, with all segments but the last at limit 0xFFFF, give contiguous addresses across the segment boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = real addressing, 1 = protected addressing |
| req_valid | input | 1 | Translation request strobe |
| req_sel | input | 16 | Segment value or selector |
| req_ofs | input | 16 | Offset within the segment |
| dw_en | input | 1 | Descriptor write enable |
| dw_idx | input | 3 | Descriptor entry to write |
| dw_base | input | 24 | Base written to the entry |
| dw_limit | input | 16 | Limit written to the entry |
| dw_valid | input | 1 | Valid flag written to the entry |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_addr | output | 24 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Limit or invalid-entry fault |

## Verification
The assertions assume that the inputs are stable from the clock edge at which a request is taken. They also assume that the checker's real-mode arithmetic (sixteen times the segment plus the offset, modulo 1 MB) describes every mode-0 request. The protected-mode cases are left to the bench, because their results depend on what was written into the descriptor cache earlier. The bench drives every input once per cycle, on the falling edge, and keeps its own copy of the descriptor contents. It updates that copy only after the expectation for any same-cycle translation has been computed, so both the assertions and the bench model see exactly the values the design takes at the next rising edge.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int unsigned XL_OFS_W   = 16;
   localparam int unsigned XL_SEG_W   = 16;
   localparam int unsigned XL_BASE_W  = 24;
   localparam int unsigned XL_LIM_W   = 16;
   localparam int unsigned XL_REAL_AW = 20;
   localparam int unsigned XL_ENTRIES = 8;

   typedef enum logic {
      XL_MODE_REAL = 1'b0,
      XL_MODE_PROT = 1'b1
   } xl_mode_e;

endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned BASE_W  = 24,
   parameter int unsigned LIM_W   = 16,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [LIM_W-1:0]  wr_limit,
   input  logic              wr_vld,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BASE_W-1:0] rd_base,
   output logic [LIM_W-1:0]  rd_limit,
   output logic              rd_vld
);

   logic [BASE_W-1:0] base_q  [ENTRIES];
   logic [LIM_W-1:0]  limit_q [ENTRIES];
   logic              vld_q   [ENTRIES];

   if (ENTRIES < 2) begin : g_bad_entries
      $error("seg_desc_cache: ENTRIES must be at least 2");
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[e]  <= '0;
            limit_q[e] <= '0;
            vld_q[e]   <= 1'b0;
         end else if (hit) begin
            base_q[e]  <= wr_base;
            limit_q[e] <= wr_limit;
            vld_q[e]   <= wr_vld;
         end
      end
   end

   always_comb begin
      rd_base  = '0;
      rd_limit = '0;
      rd_vld   = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (rd_idx == IDX_W'(e)) begin
            rd_base  = base_q[e];
            rd_limit = limit_q[e];
            rd_vld   = vld_q[e];
         end
      end
   end

endmodule

// File: rtl/seg_real_addr.sv
module seg_real_addr #(
   parameter int unsigned SEG_W   = 16,
   parameter int unsigned OFS_W   = 16,
   parameter int unsigned REAL_AW = 20,
   parameter int unsigned ADDR_W  = 24,
   parameter bit          WRAP    = 1'b1
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFS_W-1:0]  ofs,
   output logic [ADDR_W-1:0] addr
);

   localparam int unsigned SHIFT = REAL_AW - SEG_W;

   if (REAL_AW <= SEG_W) begin : g_bad_shift
      $error("seg_real_addr: REAL_AW must exceed SEG_W");
   end
   if (ADDR_W < REAL_AW + 1) begin : g_bad_addr
      $error("seg_real_addr: ADDR_W too narrow for the real-mode result");
   end

   logic [REAL_AW:0] full_sum;
   assign full_sum = {1'b0, seg, {SHIFT{1'b0}}} + (REAL_AW + 1)'(ofs);

   if (WRAP) begin : g_wrap
      assign addr = ADDR_W'(full_sum[REAL_AW-1:0]);
   end else begin : g_carry
      assign addr = ADDR_W'(full_sum);
   end

endmodule

// File: rtl/seg_prot_addr.sv
module seg_prot_addr #(
   parameter int unsigned OFS_W  = 16,
   parameter int unsigned BASE_W = 24,
   parameter int unsigned LIM_W  = 16
) (
   input  logic [BASE_W-1:0] base,
   input  logic [LIM_W-1:0]  limit,
   input  logic              vld,
   input  logic [OFS_W-1:0]  ofs,
   output logic [BASE_W-1:0] addr,
   output logic              fault
);

   localparam int unsigned CMP_W = (OFS_W > LIM_W) ? OFS_W : LIM_W;

   if (BASE_W < OFS_W) begin : g_bad_base
      $error("seg_prot_addr: BASE_W must be at least OFS_W");
   end

   logic over_limit;
   assign over_limit = CMP_W'(ofs) > CMP_W'(limit);
   assign fault      = !vld || over_limit;
   assign addr       = fault ? '0 : (base + BASE_W'(ofs));

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int unsigned SEG_W     = XL_SEG_W,
   parameter int unsigned OFS_W     = XL_OFS_W,
   parameter int unsigned BASE_W    = XL_BASE_W,
   parameter int unsigned LIM_W     = XL_LIM_W,
   parameter int unsigned REAL_AW   = XL_REAL_AW,
   parameter int unsigned ENTRIES   = XL_ENTRIES,
   parameter bit          REAL_WRAP = 1'b1,
   localparam int unsigned IDX_W    = $clog2(ENTRIES),
   localparam int unsigned ADDR_W   = BASE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic              req_valid,
   input  logic [SEG_W-1:0]  req_sel,
   input  logic [OFS_W-1:0]  req_ofs,
   input  logic              dw_en,
   input  logic [IDX_W-1:0]  dw_idx,
   input  logic [BASE_W-1:0] dw_base,
   input  logic [LIM_W-1:0]  dw_limit,
   input  logic              dw_valid,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_fault
);

   if (SEG_W < IDX_W) begin : g_bad_sel
      $error("seg_xlate: selector narrower than the entry index");
   end
   if ((1 << IDX_W) != ENTRIES) begin : g_bad_pow2
      $error("seg_xlate: ENTRIES must be a power of two");
   end

   xl_mode_e mode_e;
   assign mode_e = xl_mode_e'(mode);

   logic [BASE_W-1:0] ent_base;
   logic [LIM_W-1:0]  ent_limit;
   logic              ent_vld;

   seg_desc_cache #(
      .ENTRIES (ENTRIES),
      .BASE_W  (BASE_W),
      .LIM_W   (LIM_W)
   ) i_cache (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (dw_en),
      .wr_idx   (dw_idx),
      .wr_base  (dw_base),
      .wr_limit (dw_limit),
      .wr_vld   (dw_valid),
      .rd_idx   (req_sel[IDX_W-1:0]),
      .rd_base  (ent_base),
      .rd_limit (ent_limit),
      .rd_vld   (ent_vld)
   );

   logic [ADDR_W-1:0] real_addr;

   seg_real_addr #(
      .SEG_W   (SEG_W),
      .OFS_W   (OFS_W),
      .REAL_AW (REAL_AW),
      .ADDR_W  (ADDR_W),
      .WRAP    (REAL_WRAP)
   ) i_real (
      .seg  (req_sel),
      .ofs  (req_ofs),
      .addr (real_addr)
   );

   logic [ADDR_W-1:0] prot_addr;
   logic              prot_fault;

   seg_prot_addr #(
      .OFS_W  (OFS_W),
      .BASE_W (BASE_W),
      .LIM_W  (LIM_W)
   ) i_prot (
      .base  (ent_base),
      .limit (ent_limit),
      .vld   (ent_vld),
      .ofs   (req_ofs),
      .addr  (prot_addr),
      .fault (prot_fault)
   );

   logic [ADDR_W-1:0] nxt_addr;
   logic              nxt_fault;

   always_comb begin
      unique case (mode_e)
         XL_MODE_PROT: begin
            nxt_addr  = prot_addr;
            nxt_fault = prot_fault;
         end
         default: begin
            nxt_addr  = real_addr;
            nxt_fault = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_fault <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_fault <= req_valid && nxt_fault;
         if (req_valid) begin
            rsp_addr <= nxt_addr;
         end
      end
   end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int unsigned SEG_W   = 16,
   parameter int unsigned OFS_W   = 16,
   parameter int unsigned REAL_AW = 20,
   parameter int unsigned ADDR_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode,
   input logic              req_valid,
   input logic [SEG_W-1:0]  req_sel,
   input logic [OFS_W-1:0]  req_ofs,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic              rsp_fault
);

   localparam int unsigned SHIFT = REAL_AW - SEG_W;

   function automatic logic [ADDR_W-1:0] real_ref(input logic [SEG_W-1:0] s,
                                                  input logic [OFS_W-1:0] o);
      logic [REAL_AW-1:0] a;
      a = REAL_AW'({s, {SHIFT{1'b0}}}) + REAL_AW'(o);
      return ADDR_W'(a);
   endfunction

   // R3
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R3
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R3
   fault_only_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_fault);

   // R5
   fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_addr == '0));

   // R2
   real_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mode) |=> !rsp_fault);

   // R2
   real_addr_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mode) |=> (rsp_addr == real_ref($past(req_sel), $past(req_ofs))));

endmodule

bind seg_xlate seg_xlate_chk #(
   .SEG_W   (SEG_W),
   .OFS_W   (OFS_W),
   .REAL_AW (REAL_AW),
   .ADDR_W  (ADDR_W)
) i_seg_xlate_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .req_valid (req_valid),
   .req_sel   (req_sel),
   .req_ofs   (req_ofs),
   .rsp_valid (rsp_valid),
   .rsp_addr  (rsp_addr),
   .rsp_fault (rsp_fault)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_sel = '0;
   logic [15:0] req_ofs = '0;
   logic        dw_en = 1'b0;
   logic [2:0]  dw_idx = '0;
   logic [23:0] dw_base = '0;
   logic [15:0] dw_limit = '0;
   logic        dw_valid = 1'b0;
   logic        rsp_valid;
   logic [23:0] rsp_addr;
   logic        rsp_fault;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   seg_xlate i_seg_xlate (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .req_valid (req_valid),
      .req_sel   (req_sel),
      .req_ofs   (req_ofs),
      .dw_en     (dw_en),
      .dw_idx    (dw_idx),
      .dw_base   (dw_base),
      .dw_limit  (dw_limit),
      .dw_valid  (dw_valid),
      .rsp_valid (rsp_valid),
      .rsp_addr  (rsp_addr),
      .rsp_fault (rsp_fault)
   );

   // bench model of the descriptor contents
   logic [23:0] m_base  [8];
   logic [15:0] m_limit [8];
   logic        m_vld   [8];

   typedef struct {
      logic [23:0] addr;
      logic        fault;
      string       tag;
   } exp_t;

   exp_t sb[$];

   function automatic exp_t model(input logic prot, input logic [15:0] s,
                                  input logic [15:0] o, input string tag);
      exp_t r;
      logic [19:0] ra;
      int i;
      r.tag = tag;
      if (!prot) begin
         ra      = {s[15:0], 4'h0} + {4'h0, o};
         r.addr  = {4'h0, ra};
         r.fault = 1'b0;
      end else begin
         i = int'(s[2:0]);
         if (!m_vld[i] || o > m_limit[i]) begin
            r.addr  = '0;
            r.fault = 1'b1;
         end else begin
            r.addr  = m_base[i] + {8'h0, o};
            r.fault = 1'b0;
         end
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
      dw_en     = 1'b0;
   endtask

   task automatic wr(input logic [2:0] i, input logic [23:0] b,
                     input logic [15:0] l, input logic v);
      @(negedge clk);
      req_valid = 1'b0;
      dw_en = 1'b1; dw_idx = i; dw_base = b; dw_limit = l; dw_valid = v;
      m_base[i] = b; m_limit[i] = l; m_vld[i] = v;
   endtask

   // request with an optional same-cycle descriptor write (R8)
   task automatic xl(input logic prot, input logic [15:0] s, input logic [15:0] o,
                     input string tag, input bit with_wr = 1'b0,
                     input logic [2:0] wi = '0, input logic [23:0] wb = '0,
                     input logic [15:0] wl = '0, input logic wv = 1'b0);
      @(negedge clk);
      mode = prot; req_sel = s; req_ofs = o; req_valid = 1'b1;
      sb.push_back(model(prot, s, o, tag));
      dw_en = with_wr;
      if (with_wr) begin
         dw_idx = wi; dw_base = wb; dw_limit = wl; dw_valid = wv;
         m_base[wi] = wb; m_limit[wi] = wl; m_vld[wi] = wv;
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (rst_n) begin
            if (rsp_valid && sb.size() == 0) begin
               check("R3 unexpected response", 32'(rsp_valid), 32'd0);
            end else if (!rsp_valid && sb.size() != 0) begin
               check({"R3 missing response ", sb[0].tag}, 32'(rsp_valid), 32'd1);
               void'(sb.pop_front());
            end else if (rsp_valid) begin
               exp_t e;
               e = sb.pop_front();
               check({e.tag, " addr"},  32'(rsp_addr),  32'(e.addr));
               check({e.tag, " fault"}, 32'(rsp_fault), 32'(e.fault));
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_base[i] = '0; m_limit[i] = '0; m_vld[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      // R1: outputs held at zero under reset
      check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
      check("R1 rsp_fault", 32'(rsp_fault), 32'd0);
      check("R1 rsp_addr",  32'(rsp_addr),  32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 / R6: every entry invalid after reset
      for (int i = 0; i < 8; i++) xl(1'b1, 16'(i), 16'h0000, "R1 entry invalid");
      idle();

      // R2: real mode, plain, wrap at 1 MB, top of window
      xl(1'b0, 16'h1234, 16'h0005, "R2 real basic");
      xl(1'b0, 16'hFFFF, 16'h0010, "R2 real wrap");
      xl(1'b0, 16'hF000, 16'hFFFF, "R2 real top");
      idle();

      // R8: load descriptors
      wr(3'd0, 24'h123400, 16'h00FF, 1'b1);
      wr(3'd1, 24'h123500, 16'hFFFF, 1'b1);
      wr(3'd2, 24'h133500, 16'h0FFF, 1'b1);
      wr(3'd3, 24'hFFFF00, 16'hFFFF, 1'b1);
      wr(3'd5, 24'h050000, 16'h1000, 1'b1);
      idle();

      // R4 / R5: limit edge
      xl(1'b1, 16'h0000, 16'h00FF, "R4 offset at limit");
      xl(1'b1, 16'h0000, 16'h0100, "R5 offset over limit");
      xl(1'b1, 16'h0002, 16'h1000, "R5 over limit entry 2");
      xl(1'b1, 16'h0003, 16'h0200, "R4 wrap 2^24");
      xl(1'b1, 16'h0005, 16'h0800, "R4 entry 5");
      idle();

      // R8: invalidate entry 5
      wr(3'd5, 24'h050000, 16'h1000, 1'b0);
      idle();
      xl(1'b1, 16'h0005, 16'h0800, "R6 invalidated entry");
      xl(1'b1, 16'h0004, 16'h0000, "R6 never written");

      // R7: upper selector bits ignored
      xl(1'b1, 16'h0009, 16'h0010, "R7 sel 0x0009");
      xl(1'b1, 16'hFFF8, 16'h0010, "R7 sel 0xFFF8");

      // R10: contiguous across adjacent selectors
      xl(1'b1, 16'h0001, 16'hFFFF, "R10 end of seg 1");
      xl(1'b1, 16'h0002, 16'h0000, "R10 start of seg 2");

      // R9: alternating modes back to back
      xl(1'b0, 16'h0001, 16'h0002, "R9 real");
      xl(1'b1, 16'h0001, 16'h0002, "R9 prot");
      xl(1'b0, 16'h0001, 16'h0002, "R9 real again");

      // R8: write and translate same entry in the same cycle
      xl(1'b1, 16'h0006, 16'h0004, "R8 same-cycle old contents",
         1'b1, 3'd6, 24'h000010, 16'h0010, 1'b1);
      xl(1'b1, 16'h0006, 16'h0004, "R8 after write");
      idle();
      repeat (3) @(negedge clk);

      // R3: every request answered
      check("R3 scoreboard drained", 32'(sb.size()), 32'd0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule